// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software reach the management registers of external Ethernet PHYs over a two-wire serial management bus. Software writes one 32-bit command word that holds the PHY address, the register number, a read or write request bit and, for a write, the 16-bit value. The engine runs one clause-22 management frame on the clock and data pins. It then raises a sticky completion flag in a 32-bit status word. For a read, the returned register value sits in the upper half of that word.

Software polls the status word. Before a read it expects the read-ready flag to be clear, and it waits for the flag to set once the read is issued. A write follows the same pattern with the write-done flag. Accepting a command clears only the flag that belongs to it, so the other flag and the last read value stay visible. The management clock is the system clock divided by an even parameter. It runs only while a frame is in flight. The data pin is released for the turnaround and data bits of a read.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, status_o reads 0xFFFF0000, so both flags are clear and the read data is 0xFFFF. mdc_o is low and mdio_oe_o is low.
- R2: Command fields are PHY address in bits 4:0, register number in bits 12:8 and write data in bits 31:16. Bit 14 requests a read and bit 13 requests a write. If both bits are set the command is a read. If neither is set the command is ignored.
- R3: On the clock edge that accepts a read, status bit 1 (read-ready) clears and status bits 31:16 become 0xFFFF. On the edge that accepts a write, status bit 0 (write-done) clears. The other flag is left unchanged.
- R4: mdc_o is low whenever the engine is idle. During a frame each bit lasts MDC_DIV clock cycles: mdc_o is low for the first MDC_DIV/2 cycles and high for the rest. A frame is 64 such bit periods, starting on the cycle after acceptance.
- R5: A write frame drives, MSB first: 32 ones, then 01, then opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits. mdio_oe_o is high for all 64 bits.
- R6: A read frame drives 32 ones, 01, opcode 10, the PHY address and the register number (46 bits). It then holds mdio_oe_o low for the turnaround and the 16 data bits. Each data bit is sampled from mdio_i on the clock edge where mdc_o rises, with the first sampled bit becoming bit 15.
- R7: The matching flag (bit 0 for a write, bit 1 for a read) sets on the edge that ends the last bit period, which is 64*MDC_DIV cycles after the accepting edge. It stays set until the next command of the same kind is accepted.
- R8: When a read frame completes, status bits 31:16 hold the 16 sampled bits. A write frame leaves them unchanged, whatever mdio_i does.
- R9: A command presented while a frame is in flight is ignored. It changes neither the flags, nor the read data, nor the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | One-cycle strobe that writes the command word |
| cmd_data_i | input | 32 | Command word |
| status_o | output | 32 | Status word: read data in 31:16, read-ready in bit 1, write-done in bit 0 |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A behavioural model in the bench tracks the pins and the status word on every clock and compares them with the design.

- Write frames with alternating and extreme data patterns show that the fields are placed in the right frame positions and that the opcode is correct. A toggling mdio_i during these frames shows that input noise cannot disturb the read data.
- Reads that return patterns with a lone MSB, all ones and mixed bits show that sampling happens on the correct MDC edge and in the correct bit order.
- A command with both request bits set tells read priority apart from write priority.
- A command with no request bit, and a command issued in the middle of a frame, show that the flags, the read value and the frame in flight do not move.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int unsigned PHY_W       = 5;
  localparam int unsigned REG_W       = 5;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned PREAMBLE_W  = 32;
  localparam int unsigned FRAME_BITS  = PREAMBLE_W + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int unsigned BIT_IDX_W   = $clog2(FRAME_BITS);
  // first bit index that a read leaves undriven (turnaround)
  localparam int unsigned RD_REL_BIT  = FRAME_BITS - DATA_W - 2;
  localparam int unsigned RD_DATA_BIT = FRAME_BITS - DATA_W;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e              op;
    logic [PHY_W-1:0]      phy;
    logic [REG_W-1:0]      regad;
    logic [DATA_W-1:0]     wdata;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    logic [1:0] opc;
    opc = (c.op == OP_READ) ? 2'b10 : 2'b01;
    return {{PREAMBLE_W{1'b1}}, 2'b01, opc, c.phy, c.regad, 2'b10, c.wdata};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic bit_end_o
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] PRE_RISE = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(HALF);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)     cnt_d = '0;
    else if (run_i)  cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= run_i && !start_i && (cnt_d >= HALF_C);
    end
  end

  assign mdc_o     = mdc_q;
  assign rise_o    = run_i && (cnt_q == PRE_RISE);
  assign bit_end_o = run_i && (cnt_q == LAST);

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_o);
  // R4
  mdc_rise_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              bit_end_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output mdio_op_e          done_op_o,
  output logic [DATA_W-1:0] capt_o
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);
  localparam logic [BIT_IDX_W-1:0] REL_BIT  = BIT_IDX_W'(RD_REL_BIT);
  localparam logic [BIT_IDX_W-1:0] DAT_BIT  = BIT_IDX_W'(RD_DATA_BIT);

  logic                   busy_q;
  mdio_op_e               op_q;
  logic [FRAME_BITS-1:0]  frame_q;
  logic [BIT_IDX_W-1:0]   bit_q;
  logic [DATA_W-1:0]      capt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      op_q    <= OP_WRITE;
      frame_q <= '1;
      bit_q   <= '0;
      capt_q  <= '1;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      op_q    <= cmd_i.op;
      frame_q <= build_frame(cmd_i);
      bit_q   <= '0;
      capt_q  <= '1;
    end else if (busy_q) begin
      if (rise_i && op_q == OP_READ && bit_q >= DAT_BIT)
        capt_q <= {capt_q[DATA_W-2:0], mdio_i};
      if (bit_end_i) begin
        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
        bit_q   <= bit_q + BIT_IDX_W'(1);
        if (bit_q == LAST_BIT) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? frame_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(op_q == OP_READ && bit_q >= REL_BIT);
  assign done_o    = busy_q && bit_end_i && (bit_q == LAST_BIT);
  assign done_op_o = op_q;
  assign capt_o    = capt_q;

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
  // R7
  done_ends_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int unsigned MDC_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_data_i,
  output logic [31:0] status_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int unsigned CMD_PHY_LSB = 0;
  localparam int unsigned CMD_REG_LSB = 8;
  localparam int unsigned CMD_WR_BIT  = 13;
  localparam int unsigned CMD_RD_BIT  = 14;
  localparam int unsigned CMD_DAT_LSB = 16;

  logic              req_rd, req_wr, start;
  mdio_cmd_t         cmd;
  logic              busy, rise, bit_end, done;
  mdio_op_e          done_op;
  logic [DATA_W-1:0] capt;
  logic              wr_done_q, rd_rdy_q;
  logic [DATA_W-1:0] rd_data_q;

  assign req_rd = cmd_data_i[CMD_RD_BIT];
  assign req_wr = cmd_data_i[CMD_WR_BIT];
  assign start  = cmd_wr_i && !busy && (req_rd || req_wr);

  always_comb begin
    cmd.op    = req_rd ? OP_READ : OP_WRITE;
    cmd.phy   = cmd_data_i[CMD_PHY_LSB +: PHY_W];
    cmd.regad = cmd_data_i[CMD_REG_LSB +: REG_W];
    cmd.wdata = cmd_data_i[CMD_DAT_LSB +: DATA_W];
  end

  mdio_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (busy),
    .mdc_o     (mdc_o),
    .rise_o    (rise),
    .bit_end_o (bit_end)
  );

  mdio_frame_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (cmd),
    .rise_i    (rise),
    .bit_end_i (bit_end),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .done_op_o (done_op),
    .capt_o    (capt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_done_q <= 1'b0;
      rd_rdy_q  <= 1'b0;
      rd_data_q <= '1;
    end else if (start) begin
      if (cmd.op == OP_READ) begin
        rd_rdy_q  <= 1'b0;
        rd_data_q <= '1;
      end else begin
        wr_done_q <= 1'b0;
      end
    end else if (done) begin
      if (done_op == OP_READ) begin
        rd_rdy_q  <= 1'b1;
        rd_data_q <= capt;
      end else begin
        wr_done_q <= 1'b1;
      end
    end
  end

  assign status_o = {rd_data_q, 14'b0, rd_rdy_q, wr_done_q};

  // R3
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && req_rd) |=> (!status_o[1] && status_o[31:16] == 16'hFFFF));
  // R3
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !req_rd) |=> !status_o[0]);
  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && done_op == OP_WRITE) |=> status_o[0]);
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_wr_i && !done) |=> $stable(status_o));
  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);
endmodule

// File: tb/mdio_cmd_engine_tb_top.sv
module mdio_cmd_engine_tb_top;
  localparam int DIV       = 4;
  localparam int HALF      = DIV / 2;
  localparam int FRAME_CYC = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [31:0] status;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  always #5 clk = ~clk;

  mdio_cmd_engine #(.MDC_DIV(DIV)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_wr_i   (cmd_wr),
    .cmd_data_i (cmd_data),
    .status_o   (status),
    .mdc_o      (mdc),
    .mdio_o     (mdio_out),
    .mdio_oe_o  (mdio_oe),
    .mdio_i     (mdio_in)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // reference model state
  logic        m_busy = 1'b0;
  int          m_t    = 0;
  logic        m_rd_op = 1'b0;
  logic [63:0] m_frame = '1;
  logic [15:0] m_cap = '1;
  logic [15:0] m_rd  = 16'hFFFF;
  logic        m_wd  = 1'b0;
  logic        m_rr  = 1'b0;
  logic [15:0] phy_resp = 16'h0000;

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 1'b0; m_t = 0; m_wd = 1'b0; m_rr = 1'b0; m_rd = 16'hFFFF;
    end else if (m_busy) begin
      if ((m_t % DIV) == HALF - 1 && m_rd_op && (m_t / DIV) >= 48)
        m_cap = {m_cap[14:0], mdio_in};
      if (m_t == FRAME_CYC - 1) begin
        m_busy = 1'b0;
        m_t = 0;
        if (m_rd_op) begin m_rr = 1'b1; m_rd = m_cap; end
        else m_wd = 1'b1;
      end else begin
        m_t++;
      end
    end else if (cmd_wr && (cmd_data[14] || cmd_data[13])) begin
      m_busy  = 1'b1;
      m_t     = 0;
      m_rd_op = cmd_data[14];
      m_frame = exp_frame(cmd_data[14], cmd_data[4:0], cmd_data[12:8], cmd_data[31:16]);
      if (m_rd_op) begin m_rr = 1'b0; m_rd = 16'hFFFF; end
      else m_wd = 1'b0;
    end
  end

  // PHY responder: drives read data during the released data bits, noise otherwise
  always @(negedge clk) begin
    if (m_busy && m_rd_op && (m_t / DIV) >= 48)
      mdio_in = phy_resp[63 - (m_t / DIV)];
    else
      mdio_in = cyc[0] ^ cyc[2];
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3/R7 flags", {30'b0, status[1:0]}, {30'b0, m_rr, m_wd});
      chk("R8 rd_data", {16'b0, status[31:16]}, {16'b0, m_rd});
      chk("R4 mdc", {31'b0, mdc}, {31'b0, m_busy && ((m_t % DIV) >= HALF)});
      chk("R6 mdio_oe", {31'b0, mdio_oe},
          {31'b0, m_busy && !(m_rd_op && (m_t / DIV) >= 46)});
      if (m_busy && mdio_oe)
        chk("R5 mdio_o", {31'b0, mdio_out}, {31'b0, m_frame[63 - (m_t / DIV)]});
    end
  end

  task automatic issue(logic [31:0] c);
    @(negedge clk);
    cmd_wr   = 1'b1;
    cmd_data = c;
    @(negedge clk);
    cmd_wr   = 1'b0;
    cmd_data = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(logic rd, logic wr, logic [4:0] phy, logic [4:0] rg,
                                     logic [15:0] wd);
    return {wd, 1'b0, rd, wr, rg, 3'b000, phy};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'hFFFF_0000);
    chk("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", status, 32'hFFFF_0000);

    // R5 write, alternating data
    issue(mk(1'b0, 1'b1, 5'd5, 5'd31, 16'hA55A));
    @(negedge clk);
    chk("R3 wr_done clear", {31'b0, status[0]}, 32'h0);
    wait_idle();
    chk("R7 wr_done set", {31'b0, status[0]}, 32'h1);
    chk("R8 write leaves rd_data", {16'b0, status[31:16]}, 32'hFFFF);

    // R6 read, mixed pattern
    phy_resp = 16'h3C96;
    issue(mk(1'b1, 1'b0, 5'd18, 5'd3, 16'h1234));
    wait_idle();
    chk("R8 read data", {16'b0, status[31:16]}, 32'h3C96);
    chk("R7 rd_rdy set, wr_done kept", {30'b0, status[1:0]}, 32'h3);

    // R9 write issued mid-read is ignored
    phy_resp = 16'h8000;
    issue(mk(1'b1, 1'b0, 5'd31, 5'd31, 16'h0000));
    repeat (40) @(negedge clk);
    issue(mk(1'b0, 1'b1, 5'd1, 5'd1, 16'hFFFF));
    chk("R9 wr_done untouched mid-frame", {31'b0, status[0]}, 32'h1);
    wait_idle();
    chk("R9 read finished unharmed", {16'b0, status[31:16]}, 32'h8000);
    chk("R9 wr_done still set", {31'b0, status[0]}, 32'h1);

    // R2 both bits: read wins
    phy_resp = 16'hFFFF;
    issue(mk(1'b1, 1'b1, 5'd0, 5'd0, 16'h00FF));
    @(negedge clk);
    chk("R2 both bits clears rd_rdy", {30'b0, status[1:0]}, 32'h1);
    wait_idle();
    chk("R2 both bits reads", status, 32'hFFFF_0003);

    // R2 neither bit: ignored
    phy_resp = 16'h0001;
    issue(mk(1'b0, 1'b0, 5'd7, 5'd7, 16'h5555));
    repeat (6) @(negedge clk);
    chk("R2 no request, status", status, 32'hFFFF_0003);
    chk("R2 no request, pins", {30'b0, mdc, mdio_oe}, 32'h0);

    // R8 read of lone LSB then write with all zeros
    issue(mk(1'b1, 1'b0, 5'd9, 5'd16, 16'h0000));
    wait_idle();
    chk("R8 lsb read", {16'b0, status[31:16]}, 32'h0001);
    issue(mk(1'b0, 1'b1, 5'd30, 5'd0, 16'h0000));
    wait_idle();
    chk("R8 rd_data kept over write", status, 32'h0001_0003);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule